// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the address and transfer-count state of a single DMA channel. For each transfer the channel is granted, it produces the physical memory address and the active byte lanes. Software loads a 16-bit start address, a 16-bit count and an 8-bit page value. The page value is a fixed upper part of the address. The 16-bit address never carries into it, so every transfer stays inside one page.

Every unmasked transfer acknowledge does three things in the same clock edge. It registers the physical address for that transfer, it steps the current address up or down, and it decrements the current count. When the count steps from zero to all ones, the block reports terminal count. At that point it either reloads the current registers from the base registers (auto-init) or masks the channel.

A parameter sets the channel type. A byte channel moves one byte per step. A word channel moves one 16-bit word per step, shifts the address left by one and ignores bit 0 of the page.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset the channel is masked, the current address, current count and page are zero, and `addr_vld` and `tc` are low.
- R2: On a byte channel (`WORD_CHAN=0`), `phys_addr` is {page[7:0], address[15:0]}. `byte_en` is 2'b01 for an even address and 2'b10 for an odd address.
- R3: On a word channel (`WORD_CHAN=1`), `phys_addr` is {page[7:1], address[15:0], 1'b0}. Page bit 0 is ignored and `byte_en` is 2'b11.
- R4: An acknowledge on an unmasked channel produces `addr_vld` high in the next cycle, with `phys_addr` formed from the address held before that acknowledge.
- R5: The current address increments by one after each transfer. With `addr_down` high it decrements by one instead. Either way it wraps within 16 bits and never changes the page.
- R6: Each transfer decrements the current count by one. A loaded count N gives N+1 transfers, so 0x0000 gives one transfer and 0xFFFF gives 65536.
- R7: `tc` is high for exactly the one transfer in which the count steps from 0x0000 to 0xFFFF.
- R8: At terminal count without auto-init, the channel becomes masked and the count reads 0xFFFF.
- R9: At terminal count with `autoinit` high, the current address and count are reloaded from the base values and the channel stays unmasked.
- R10: An acknowledge while the channel is masked has no effect: `addr_vld` stays low and the current address and count are unchanged.
- R11: A write of the address or count updates both the base and the current register. In the same cycle, the write takes priority over a transfer's update of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Write `reg_wdata` to base and current address |
| cnt_we | input | 1 | Write `reg_wdata` to base and current count |
| reg_wdata | input | 16 | Address or count write data |
| page_we | input | 1 | Write `page_wdata` to the page register |
| page_wdata | input | 8 | Page write data |
| autoinit | input | 1 | Reload from base at terminal count |
| addr_down | input | 1 | Decrement address instead of incrementing |
| unmask | input | 1 | Clear the channel mask |
| xfer_ack | input | 1 | Transfer acknowledge, one per transfer |
| phys_addr | output | 24 | Registered physical address of the last transfer |
| byte_en | output | 2 | Registered byte lanes of the last transfer |
| addr_vld | output | 1 | `phys_addr`/`byte_en` belong to a transfer this cycle |
| tc | output | 1 | Terminal count on that transfer |
| masked | output | 1 | Channel mask state |
| cur_addr | output | 16 | Current address register |
| cur_cnt | output | 16 | Current count register |

## Verification
The bench builds two copies of the block side by side: one with `WORD_CHAN=0` and one with `WORD_CHAN=1`. Both copies receive identical stimulus, so every address vector is checked against the byte mapping and the word mapping at once. This covers the page-bit-0 masking, the left shift and the lane selection. One long run with a loaded count of 0xFFFF on the byte copy reaches the full 65536-transfer range and shows that exactly one terminal count occurs, on the last transfer.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef struct packed {
    logic reload;
    logic down;
  } xfer_mode_t;

  function automatic logic [15:0] next_addr16(input logic [15:0] a, input logic down);
    next_addr16 = down ? (a - 16'd1) : (a + 16'd1);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic [ADDR_W-1:0] wdata,
  input  xfer_mode_t        mode,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_cnt,
  output logic              tc_hit
);

  logic [ADDR_W-1:0] base_addr_q;
  logic [ADDR_W-1:0] base_cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cnt_q;

  assign tc_hit = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      addr_q      <= '0;
    end else if (addr_we) begin
      base_addr_q <= wdata;
      addr_q      <= wdata;
    end else if (step) begin
      if (tc_hit && mode.reload) begin
        addr_q <= base_addr_q;
      end else begin
        addr_q <= mode.down ? (addr_q - 1'b1) : (addr_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt_q <= '0;
      cnt_q      <= '0;
    end else if (cnt_we) begin
      base_cnt_q <= wdata;
      cnt_q      <= wdata;
    end else if (step) begin
      if (tc_hit && mode.reload) begin
        cnt_q <= base_cnt_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;

endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int PHYS_W   = ADDR_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  output logic [PHYS_W-1:0] phys,
  output logic [1:0]        lanes
);

  generate
    if (WORD_CHAN) begin : g_word
      assign phys  = {page[PAGE_W-1:1], addr, 1'b0};
      assign lanes = 2'b11;
    end else begin : g_byte
      assign phys  = {page, addr};
      assign lanes = addr[0] ? 2'b10 : 2'b01;
    end
  endgenerate

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int PHYS_W   = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              autoinit,
  input  logic              addr_down,
  input  logic              unmask,
  input  logic              xfer_ack,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [1:0]        byte_en,
  output logic              addr_vld,
  output logic              tc,
  output logic              masked,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_cnt
);

  xfer_mode_t        mode;
  logic              step;
  logic              tc_hit;
  logic [PAGE_W-1:0] page_q;
  logic              mask_q;
  logic [PHYS_W-1:0] phys_c;
  logic [1:0]        lanes_c;

  assign mode.reload = autoinit;
  assign mode.down   = addr_down;
  assign step        = xfer_ack && !mask_q;

  dma_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_we  (addr_we),
    .cnt_we   (cnt_we),
    .wdata    (reg_wdata),
    .mode     (mode),
    .step     (step),
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .tc_hit   (tc_hit)
  );

  dma_phys_map #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .WORD_CHAN (WORD_CHAN)
  ) u_map (
    .page  (page_q),
    .addr  (cur_addr),
    .phys  (phys_c),
    .lanes (lanes_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (page_we) begin
      page_q <= page_wdata;
    end
  end

  // terminal count masking wins over an unmask in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
    end else if (tc_hit && !autoinit) begin
      mask_q <= 1'b1;
    end else if (unmask) begin
      mask_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      byte_en   <= '0;
      addr_vld  <= 1'b0;
      tc        <= 1'b0;
    end else begin
      addr_vld <= step;
      tc       <= tc_hit;
      if (step) begin
        phys_addr <= phys_c;
        byte_en   <= lanes_c;
      end
    end
  end

  assign masked = mask_q;

endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cnt_we,
  input logic                     addr_we,
  input logic                     autoinit,
  input logic                     xfer_ack,
  input logic                     masked,
  input logic                     addr_vld,
  input logic                     tc,
  input logic [1:0]               byte_en,
  input logic [ADDR_W+PAGE_W-1:0] phys_addr,
  input logic [ADDR_W-1:0]        cur_addr,
  input logic [ADDR_W-1:0]        cur_cnt
);

  // R7
  tc_with_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> addr_vld);

  // R4
  ack_gives_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && !masked) |=> addr_vld);

  // R10
  masked_ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && masked && !addr_we && !cnt_we) |=> (!addr_vld && $stable(cur_addr) && $stable(cur_cnt)));

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && !masked && !cnt_we && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - 1'b1));

  // R8
  tc_masks_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && !masked && !cnt_we && !autoinit && cur_cnt == '0) |=> (masked && tc && cur_cnt == '1));

  // R3
  always_comb begin
    if (!rst && WORD_CHAN && addr_vld) begin
      word_lanes_chk: assert (byte_en == 2'b11 && phys_addr[0] == 1'b0);
    end
  end

endmodule

bind dma_addr_engine dma_addr_engine_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_W    (PAGE_W),
  .WORD_CHAN (WORD_CHAN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_we    (cnt_we),
  .addr_we   (addr_we),
  .autoinit  (autoinit),
  .xfer_ack  (xfer_ack),
  .masked    (masked),
  .addr_vld  (addr_vld),
  .tc        (tc),
  .byte_en   (byte_en),
  .phys_addr (phys_addr),
  .cur_addr  (cur_addr),
  .cur_cnt   (cur_cnt)
);

// File: tb/test_dma_addr_engine.sv
module test_dma_addr_engine;

  typedef struct packed {
    logic [7:0]  page;
    logic [15:0] addr;
    logic        down;
    logic [23:0] b1;
    logic [23:0] b2;
    logic [23:0] w1;
    logic [23:0] w2;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'h12, 16'h3456, 1'b0, 24'h123456, 24'h123457, 24'h1268AC, 24'h1268AE},
    '{8'h13, 16'hFFFF, 1'b0, 24'h13FFFF, 24'h130000, 24'h13FFFE, 24'h120000},
    '{8'hFF, 16'h0000, 1'b1, 24'hFF0000, 24'hFFFFFF, 24'hFE0000, 24'hFFFFFE},
    '{8'h00, 16'h8001, 1'b0, 24'h008001, 24'h008002, 24'h010002, 24'h010004}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_we = 0, cnt_we = 0, page_we = 0, autoinit = 0, addr_down = 0, unmask = 0, xfer_ack = 0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  page_wdata = '0;

  logic [23:0] pa_b, pa_w;
  logic [1:0]  be_b, be_w;
  logic        vld_b, vld_w, tc_b, tc_w, msk_b, msk_w;
  logic [15:0] ca_b, ca_w, cc_b, cc_w;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_addr_engine #(.WORD_CHAN(1'b0)) i_dma_addr_engine (
    .clk(clk), .rst(rst), .addr_we(addr_we), .cnt_we(cnt_we), .reg_wdata(reg_wdata),
    .page_we(page_we), .page_wdata(page_wdata), .autoinit(autoinit), .addr_down(addr_down),
    .unmask(unmask), .xfer_ack(xfer_ack), .phys_addr(pa_b), .byte_en(be_b), .addr_vld(vld_b),
    .tc(tc_b), .masked(msk_b), .cur_addr(ca_b), .cur_cnt(cc_b));

  dma_addr_engine #(.WORD_CHAN(1'b1)) i_dma_addr_engine_word (
    .clk(clk), .rst(rst), .addr_we(addr_we), .cnt_we(cnt_we), .reg_wdata(reg_wdata),
    .page_we(page_we), .page_wdata(page_wdata), .autoinit(autoinit), .addr_down(addr_down),
    .unmask(unmask), .xfer_ack(xfer_ack), .phys_addr(pa_w), .byte_en(be_w), .addr_vld(vld_w),
    .tc(tc_w), .masked(msk_w), .cur_addr(ca_w), .cur_cnt(cc_w));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [15:0] v);
    @(negedge clk); addr_we = 1; reg_wdata = v;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; reg_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic wr_page(input logic [7:0] v);
    @(negedge clk); page_we = 1; page_wdata = v;
    @(negedge clk); page_we = 0;
  endtask

  task automatic do_unmask();
    @(negedge clk); unmask = 1;
    @(negedge clk); unmask = 0;
  endtask

  // one acknowledge; on return the registered outputs of that transfer are visible
  task automatic ack1();
    @(negedge clk); xfer_ack = 1;
    @(negedge clk); xfer_ack = 0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tc_seen;
    int tc_at;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 masked", {31'd0, msk_b}, 32'd1);
    check("R1 cur_addr", {16'd0, ca_b}, 32'd0);
    check("R1 cur_cnt", {16'd0, cc_b}, 32'd0);
    check("R1 vld/tc", {30'd0, vld_b, tc_b}, 32'd0);

    // R10 ack while masked is ignored
    wr_addr(16'h0040);
    ack1();
    check("R10 no vld", {31'd0, vld_b}, 32'd0);
    check("R10 addr kept", {16'd0, ca_b}, 32'h0040);
    check("R10 cnt kept", {16'd0, cc_b}, 32'd0);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 4; i++) begin
      wr_page(VEC[i].page);
      wr_addr(VEC[i].addr);
      wr_cnt(16'd5);
      addr_down = VEC[i].down;
      do_unmask();
      ack1();
      check("R4 vld", {30'd0, vld_b, vld_w}, 32'd3);
      check("R2 byte phys 1", {8'd0, pa_b}, {8'd0, VEC[i].b1});
      check("R2 byte lanes 1", {30'd0, be_b}, VEC[i].b1[0] ? 32'd2 : 32'd1);
      check("R3 word phys 1", {8'd0, pa_w}, {8'd0, VEC[i].w1});
      check("R3 word lanes", {30'd0, be_w}, 32'd3);
      ack1();
      check("R5 byte phys 2", {8'd0, pa_b}, {8'd0, VEC[i].b2});
      check("R5 word phys 2", {8'd0, pa_w}, {8'd0, VEC[i].w2});
      check("R6 cnt after 2", {16'd0, cc_b}, 32'd3);
      check("R7 no tc", {30'd0, tc_b, tc_w}, 32'd0);
    end
    addr_down = 0;

    // R6 R7 R8 loaded zero gives one transfer then mask
    wr_cnt(16'h0000);
    ack1();
    check("R7 tc on single", {31'd0, tc_b}, 32'd1);
    check("R8 masked", {30'd0, msk_b, msk_w}, 32'd3);
    check("R8 cnt wraps", {16'd0, cc_b}, 32'hFFFF);
    @(negedge clk);
    check("R7 tc one cycle", {31'd0, tc_b}, 32'd0);

    // R9 autoinit reload
    autoinit = 1;
    wr_addr(16'h1000);
    wr_cnt(16'h0001);
    do_unmask();
    ack1();
    check("R9 first no tc", {31'd0, tc_b}, 32'd0);
    ack1();
    check("R9 tc", {31'd0, tc_b}, 32'd1);
    check("R9 addr reload", {16'd0, ca_b}, 32'h1000);
    check("R9 cnt reload", {16'd0, cc_b}, 32'h0001);
    check("R9 stays unmasked", {31'd0, msk_b}, 32'd0);
    autoinit = 0;

    // R11 write beats a transfer in the same cycle
    @(negedge clk); xfer_ack = 1; cnt_we = 1; reg_wdata = 16'h0077;
    @(negedge clk); xfer_ack = 0; cnt_we = 0;
    check("R11 cnt write wins", {16'd0, cc_b}, 32'h0077);
    check("R11 addr stepped", {16'd0, ca_b}, 32'h1001);

    // R6 R7 full count 0xFFFF on the byte channel
    wr_cnt(16'hFFFF);
    tc_seen = 0; tc_at = 0;
    @(negedge clk); xfer_ack = 1;
    for (int n = 1; n <= 65536; n++) begin
      @(negedge clk);
      if (tc_b) begin tc_seen++; tc_at = n; end
    end
    xfer_ack = 0;
    check("R7 single tc", tc_seen, 32'd1);
    check("R6 tc at 65536", tc_at, 32'd65536);
    check("R8 masked after run", {31'd0, msk_b}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule